// File: doc/BRIEF.md
# PCI Master Cycle Termination Controller

This block decides how a PCI bus master's cycle ends. Once the master starts a cycle, the block drives FRAME and IRDY and watches for a target to claim the cycle with DEVSEL. If no target claims it within four clocks, the block runs a master abort. It lowers FRAME, then IRDY, and returns to idle without starting the cycle again. It also latches two sticky status bits: a received-master-abort bit and a system interrupt flag. The interrupt flag drives INTA when its enable is set.

The block also runs a latency timer. The timer loads a programmable value when FRAME first goes high and counts down to zero. If GNT is withdrawn after the timer has reached zero, the block still completes the data phase in progress. It then drops FRAME, completes one final data phase and releases the bus. When the timer is still running, losing GNT has no effect. The burst ends normally when its programmed beat count has been transferred. All bus signals here are active-high; pad inversion belongs to the I/O ring. Address and data paths are outside this block.

Top module: `pci_master_term`

## Requirements
- R1: During reset and in the first cycle after it, frame_o, irdy_o, bus_rel_o, rma_o, sint_o and inta_o are all 0.
- R2: A cycle starts only if start_i and gnt_i are both 1 in a cycle while the block is idle (all of frame_o, irdy_o and bus_rel_o are 0). In the next cycle (the address cycle A), frame_o=1 and irdy_o=0. A start with gnt_i=0, or a start while a cycle is in progress, is ignored.
- R3: From A+1 on, irdy_o=1. A data phase completes in a cycle with irdy_o=1, devsel_i=1 and trdy_i=1. For a burst of len_i phases (0 counts as 1), frame_o is 0 from the cycle in which the final phase is pending. In the cycle after the final phase completes, irdy_o=0 and bus_rel_o=1 for exactly one cycle, and then the block is idle.
- R4: If devsel_i is 0 in every cycle from A+1 through A+4 while frame_o is still 1, then A+5 has frame_o=0 and irdy_o=1. A+6 has irdy_o=0 and bus_rel_o=1.
- R5: On a master abort, rma_o and sint_o both become 1 in the cycle after the last allowed DEVSEL clock (A+5).
- R6: inta_o is 1 exactly when sint_o is 1 and sint_en_i is 1.
- R7: rma_o and sint_o are sticky. A 1 on clr_rma_i or clr_sint_i clears the matching bit in the next cycle. A set in the same cycle as a clear wins.
- R8: After a master abort the block stays idle (frame_o=0) until a new start is requested. It never retries by itself.
- R9: The latency timer loads lat_val_i in cycle A and decrements by one per cycle down to 0. When a phase completes while gnt_i=0 and the timer is 0, frame_o drops in the next cycle. One more phase is then completed, followed by the release cycle. While the timer is nonzero, gnt_i=0 does not shorten the burst.
- R10: A DEVSEL seen in cycle A+4 (the last allowed clock) claims the cycle, and no abort or status change follows.
- R11: If the burst has only one phase (frame_o already 0 from A+1) and no DEVSEL comes by A+4, A+5 has irdy_o=0, bus_rel_o=1 and the abort status set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a cycle |
| len_i | input | LEN_W | Number of data phases in the burst (0 treated as 1) |
| lat_val_i | input | LAT_W | Latency timer load value |
| gnt_i | input | 1 | Bus grant from arbiter |
| devsel_i | input | 1 | Target claims the cycle |
| trdy_i | input | 1 | Target ready |
| sint_en_i | input | 1 | Enable from system interrupt flag to INTA |
| clr_rma_i | input | 1 | Write-one-to-clear for rma_o |
| clr_sint_i | input | 1 | Write-one-to-clear for sint_o |
| frame_o | output | 1 | FRAME driven by this master |
| irdy_o | output | 1 | IRDY driven by this master |
| bus_rel_o | output | 1 | One-cycle pulse when the bus is released |
| rma_o | output | 1 | Received master abort status |
| sint_o | output | 1 | System interrupt flag |
| inta_o | output | 1 | Interrupt request |

## Verification
The checker watches several rules on every clock. FRAME never rises without a granted start, IRDY never falls while FRAME is high, the release pulse lasts one cycle, INTA needs the flag, the flag only falls after a clear, and an idle block stays idle without a start. Only the bench scenarios can show the exact DEVSEL window boundary at A+4 and the cycle count of the latency preemption. They also show that a preempted burst ends with exactly one extra phase, that a set beats a clear in the same cycle, and that a running timer lets the burst finish.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_DATA  = 3'd2,
        ST_LAST  = 3'd3,
        ST_ABORT = 3'd4,
        ST_DONE  = 3'd5
    } pmt_state_e;

    typedef struct packed {
        logic frame;
        logic irdy;
        logic rel;
    } pmt_bus_t;

    typedef struct packed {
        logic rma;
        logic sint;
    } pmt_stat_t;

    function automatic pmt_bus_t bus_of(input pmt_state_e st);
        pmt_bus_t b;
        b = '0;
        case (st)
            ST_ADDR:  b.frame = 1'b1;
            ST_DATA:  begin b.frame = 1'b1; b.irdy = 1'b1; end
            ST_LAST:  b.irdy = 1'b1;
            ST_ABORT: b.irdy = 1'b1;
            ST_DONE:  b.rel = 1'b1;
            default:  b = '0;
        endcase
        return b;
    endfunction

    function automatic logic in_cycle(input pmt_state_e st);
        return (st == ST_ADDR) || (st == ST_DATA) || (st == ST_LAST);
    endfunction

endpackage

// File: rtl/pmt_lat_timer.sv
module pmt_lat_timer #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [LAT_W-1:0] val_i,
    input  logic             run_i,
    output logic             zero_o
);
    logic [LAT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - LAT_W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pmt_claim_watch.sv
module pmt_claim_watch #(
    parameter int DEVSEL_WIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic active_i,
    input  logic addr_i,
    input  logic devsel_i,
    output logic claimed_o,
    output logic timeout_o
);
    localparam int WD_W = $clog2(DEVSEL_WIN + 1);
    localparam logic [WD_W-1:0] LIMIT = WD_W'(DEVSEL_WIN);

    logic [WD_W-1:0] cnt_q;
    logic            claimed_q;
    logic            seen_now;

    assign seen_now = devsel_i && active_i && !addr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            claimed_q <= 1'b0;
        end else if (start_i) begin
            cnt_q     <= '0;
            claimed_q <= 1'b0;
        end else begin
            if (active_i && (cnt_q != LIMIT)) begin
                cnt_q <= cnt_q + WD_W'(1);
            end
            if (seen_now) begin
                claimed_q <= 1'b1;
            end
        end
    end

    assign claimed_o = claimed_q || seen_now;
    assign timeout_o = active_i && (cnt_q == LIMIT) && !claimed_o;
endmodule

// File: rtl/pmt_status.sv
module pmt_status
    import pmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      set_i,
    input  logic      clr_rma_i,
    input  logic      clr_sint_i,
    input  logic      en_i,
    output pmt_stat_t stat_o,
    output logic      inta_o
);
    pmt_stat_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            if (set_i) begin
                stat_q.rma <= 1'b1;
            end else if (clr_rma_i) begin
                stat_q.rma <= 1'b0;
            end
            if (set_i) begin
                stat_q.sint <= 1'b1;
            end else if (clr_sint_i) begin
                stat_q.sint <= 1'b0;
            end
        end
    end

    assign stat_o = stat_q;
    assign inta_o = stat_q.sint && en_i;
endmodule

// File: rtl/pci_master_term.sv
module pci_master_term
    import pmt_pkg::*;
#(
    parameter int LAT_W      = 8,
    parameter int LEN_W      = 4,
    parameter int DEVSEL_WIN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [LAT_W-1:0] lat_val_i,
    input  logic             gnt_i,
    input  logic             devsel_i,
    input  logic             trdy_i,
    input  logic             sint_en_i,
    input  logic             clr_rma_i,
    input  logic             clr_sint_i,
    output logic             frame_o,
    output logic             irdy_o,
    output logic             bus_rel_o,
    output logic             rma_o,
    output logic             sint_o,
    output logic             inta_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

    pmt_state_e       state_q, state_d;
    logic [LEN_W-1:0] rem_q;
    pmt_bus_t         bus;
    pmt_stat_t        stat;
    logic             active, in_addr, start_ok;
    logic             claimed, timeout, lat_zero;
    logic             complete, preempt, abort_evt;

    function automatic logic [LEN_W-1:0] beats(input logic [LEN_W-1:0] n);
        return (n == '0) ? ONE : n;
    endfunction

    assign active   = in_cycle(state_q);
    assign in_addr  = (state_q == ST_ADDR);
    assign start_ok = (state_q == ST_IDLE) && start_i && gnt_i;
    assign bus      = bus_of(state_q);

    pmt_lat_timer #(.LAT_W(LAT_W)) u_lat (
        .clk    (clk),
        .rst    (rst),
        .load_i (start_ok),
        .val_i  (lat_val_i),
        .run_i  (active),
        .zero_o (lat_zero)
    );

    pmt_claim_watch #(.DEVSEL_WIN(DEVSEL_WIN)) u_claim (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_ok),
        .active_i  (active),
        .addr_i    (in_addr),
        .devsel_i  (devsel_i),
        .claimed_o (claimed),
        .timeout_o (timeout)
    );

    assign complete  = ((state_q == ST_DATA) || (state_q == ST_LAST)) && trdy_i && claimed;
    assign preempt   = !gnt_i && lat_zero;
    assign abort_evt = timeout;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start_ok) state_d = ST_ADDR;
            ST_ADDR: state_d = (rem_q > ONE) ? ST_DATA : ST_LAST;
            ST_DATA: begin
                if (abort_evt) begin
                    state_d = ST_ABORT;
                end else if (complete && ((rem_q == TWO) || preempt)) begin
                    state_d = ST_LAST;
                end
            end
            ST_LAST:  if (abort_evt || complete) state_d = ST_DONE;
            ST_ABORT: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_ok) begin
                rem_q <= beats(len_i);
            end else if (complete) begin
                rem_q <= rem_q - ONE;
            end
        end
    end

    pmt_status u_stat (
        .clk        (clk),
        .rst        (rst),
        .set_i      (abort_evt),
        .clr_rma_i  (clr_rma_i),
        .clr_sint_i (clr_sint_i),
        .en_i       (sint_en_i),
        .stat_o     (stat),
        .inta_o     (inta_o)
    );

    assign frame_o   = bus.frame;
    assign irdy_o    = bus.irdy;
    assign bus_rel_o = bus.rel;
    assign rma_o     = stat.rma;
    assign sint_o    = stat.sint;
endmodule

// File: rtl/pmt_checker.sv
module pmt_checker (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic gnt_i,
    input logic sint_en_i,
    input logic clr_sint_i,
    input logic frame_o,
    input logic irdy_o,
    input logic bus_rel_o,
    input logic rma_o,
    input logic sint_o,
    input logic inta_o
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!frame_o && !irdy_o && !bus_rel_o && !rma_o && !sint_o));

    p_frame_needs_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!frame_o && !irdy_o && !bus_rel_o && !(start_i && gnt_i)) |=> !frame_o);

    p_start_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (!frame_o && !irdy_o && !bus_rel_o && start_i && gnt_i) |=> (frame_o && !irdy_o));

    p_irdy_outlives_frame_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(irdy_o) |-> !frame_o);

    p_rel_single_r3: assert property (@(posedge clk) disable iff (rst)
        bus_rel_o |=> !bus_rel_o);

    p_rel_idle_bus_r3: assert property (@(posedge clk) disable iff (rst)
        bus_rel_o |-> (!frame_o && !irdy_o));

    p_abort_frame_low_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(rma_o) |-> !frame_o);

    p_abort_flags_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(rma_o) |-> sint_o);

    p_inta_needs_flag_r6: assert property (@(posedge clk) disable iff (rst)
        inta_o |-> (sint_o && sint_en_i));

    p_sint_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(sint_o) |-> $past(clr_sint_i));

    p_no_retry_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rel_o && !start_i) |=> !frame_o);
endmodule

bind pci_master_term pmt_checker u_pmt_checker (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .gnt_i      (gnt_i),
    .sint_en_i  (sint_en_i),
    .clr_sint_i (clr_sint_i),
    .frame_o    (frame_o),
    .irdy_o     (irdy_o),
    .bus_rel_o  (bus_rel_o),
    .rma_o      (rma_o),
    .sint_o     (sint_o),
    .inta_o     (inta_o)
);

// File: tb/test_pci_master_term.sv
`timescale 1ns/1ps
module test_pci_master_term;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0, gnt_i = 1'b0, devsel_i = 1'b0, trdy_i = 1'b0;
    logic       sint_en_i = 1'b0, clr_rma_i = 1'b0, clr_sint_i = 1'b0;
    logic [3:0] len_i = 4'd1;
    logic [7:0] lat_val_i = 8'd200;
    logic       frame_o, irdy_o, bus_rel_o, rma_o, sint_o, inta_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    pci_master_term i_pci_master_term (
        .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i), .lat_val_i(lat_val_i),
        .gnt_i(gnt_i), .devsel_i(devsel_i), .trdy_i(trdy_i), .sint_en_i(sint_en_i),
        .clr_rma_i(clr_rma_i), .clr_sint_i(clr_sint_i), .frame_o(frame_o), .irdy_o(irdy_o),
        .bus_rel_o(bus_rel_o), .rma_o(rma_o), .sint_o(sint_o), .inta_o(inta_o)
    );

    // inputs {start,gnt,devsel,trdy,clr_rma,clr_sint,en}; expected {frame,irdy,rel,rma,sint,inta}
    task automatic cyc(input logic [6:0] in, input logic [5:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        {start_i, gnt_i, devsel_i, trdy_i, clr_rma_i, clr_sint_i, sint_en_i} = in;
        it.exp = exp;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // monitor: compare each cycle's outputs against the queued expectation
    always @(negedge clk) begin
        #2;
        if (exp_q.size() != 0) begin
            item_t it;
            logic [5:0] act;
            it  = exp_q.pop_front();
            act = {frame_o, irdy_o, bus_rel_o, rma_o, sint_o, inta_o};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%b expected=%b (frame,irdy,rel,rma,sint,inta)",
                         it.tag, act, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc(7'b0100000, 6'b000000, "R1 idle after reset");

        // R2/R3 three-beat burst, start held mid-burst is ignored
        len_i = 4'd3; lat_val_i = 8'd200;
        cyc(7'b1100000, 6'b000000, "R2 start request");
        cyc(7'b0100000, 6'b100000, "R2 address cycle");
        cyc(7'b0111000, 6'b110000, "R3 phase 1");
        cyc(7'b1111000, 6'b110000, "R2 start ignored while busy");
        cyc(7'b0111000, 6'b010000, "R3 final phase frame low");
        cyc(7'b0100000, 6'b001000, "R3 release pulse");
        cyc(7'b0100000, 6'b000000, "R3 back to idle");

        // R3 two-beat burst with a target wait state
        len_i = 4'd2;
        cyc(7'b1100000, 6'b000000, "R2 start request");
        cyc(7'b0100000, 6'b100000, "R2 address cycle");
        cyc(7'b0110000, 6'b110000, "R3 wait state");
        cyc(7'b0111000, 6'b110000, "R3 phase 1");
        cyc(7'b0111000, 6'b010000, "R3 final phase");
        cyc(7'b0100000, 6'b001000, "R3 release");
        cyc(7'b0100000, 6'b000000, "R3 idle");

        // R2 start without grant ignored
        cyc(7'b1000000, 6'b000000, "R2 start no grant");
        cyc(7'b0100000, 6'b000000, "R2 no frame without grant");

        // R4/R5/R6/R8 master abort, interrupt enabled
        len_i = 4'd4;
        cyc(7'b1100001, 6'b000000, "R4 start");
        cyc(7'b0100001, 6'b100000, "R4 address cycle");
        for (int k = 1; k <= 4; k++) cyc(7'b0100001, 6'b110000, "R4 waiting for DEVSEL");
        cyc(7'b0100001, 6'b010111, "R4 R5 R6 abort frame low, status set");
        cyc(7'b0100001, 6'b001111, "R4 abort release");
        for (int k = 0; k < 3; k++) cyc(7'b0100001, 6'b000111, "R8 no retry after abort");
        cyc(7'b0100000, 6'b000110, "R6 inta off when disabled");
        cyc(7'b0100001, 6'b000111, "R6 inta on when enabled");
        cyc(7'b0100011, 6'b000111, "R7 clear sint issued");
        cyc(7'b0100001, 6'b000100, "R7 sint cleared, rma kept");
        cyc(7'b0100101, 6'b000100, "R7 clear rma issued");
        cyc(7'b0100001, 6'b000000, "R7 rma cleared");

        // R10 DEVSEL on the last allowed clock, single-beat
        len_i = 4'd1;
        cyc(7'b1100000, 6'b000000, "R10 start");
        cyc(7'b0100000, 6'b100000, "R10 address cycle");
        for (int k = 1; k <= 3; k++) cyc(7'b0100000, 6'b010000, "R10 single beat waiting");
        cyc(7'b0111000, 6'b010000, "R10 claim at A+4");
        cyc(7'b0100000, 6'b001000, "R10 normal release, no status");
        cyc(7'b0100000, 6'b000000, "R10 idle");

        // R11 abort with frame already low; R7 set beats clear
        cyc(7'b1100000, 6'b000000, "R11 start");
        cyc(7'b0100000, 6'b100000, "R11 address cycle");
        for (int k = 1; k <= 3; k++) cyc(7'b0100000, 6'b010000, "R11 waiting");
        cyc(7'b0100110, 6'b010000, "R11 last window clock with clears");
        cyc(7'b0100000, 6'b001110, "R11 R7 release with status, set wins");
        cyc(7'b0100000, 6'b000110, "R11 idle status kept");
        cyc(7'b0100110, 6'b000110, "R7 clear both issued");
        cyc(7'b0100000, 6'b000000, "R7 both cleared");

        // R9 preemption: timer 3, grant lost, long burst
        len_i = 4'd8; lat_val_i = 8'd3;
        cyc(7'b1100000, 6'b000000, "R9 start");
        cyc(7'b0100000, 6'b100000, "R9 address cycle");
        for (int k = 1; k <= 3; k++) cyc(7'b0011000, 6'b110000, "R9 phases before expiry");
        cyc(7'b0011000, 6'b010000, "R9 preempt final phase");
        cyc(7'b0000000, 6'b001000, "R9 preempt release");
        cyc(7'b0100000, 6'b000000, "R9 idle");

        // R9 preemption while target inserts a wait state
        cyc(7'b1100000, 6'b000000, "R9 start");
        cyc(7'b0100000, 6'b100000, "R9 address cycle");
        for (int k = 1; k <= 2; k++) cyc(7'b0011000, 6'b110000, "R9 phases");
        cyc(7'b0010000, 6'b110000, "R9 current phase held");
        cyc(7'b0011000, 6'b110000, "R9 current phase completes");
        cyc(7'b0011000, 6'b010000, "R9 final phase after preempt");
        cyc(7'b0000000, 6'b001000, "R9 release");
        cyc(7'b0100000, 6'b000000, "R9 idle");

        // R9 timer still running: grant loss has no effect
        len_i = 4'd6; lat_val_i = 8'd200;
        cyc(7'b1100000, 6'b000000, "R9 start");
        cyc(7'b0100000, 6'b100000, "R9 address cycle");
        for (int k = 1; k <= 5; k++) cyc(7'b0011000, 6'b110000, "R9 burst continues");
        cyc(7'b0011000, 6'b010000, "R9 full-length final phase");
        cyc(7'b0000000, 6'b001000, "R9 release");
        cyc(7'b0100000, 6'b000000, "R9 idle");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule